// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind an ARINC 429 serial bit receiver. It takes the completed 32-bit word that the receiver presents together with a one-cycle end-of-sequence strobe. It can check the parity of the word and write the result into bit 32. It then applies up to two filters. The first filter looks up the 8-bit label in a 16-entry label table. The second compares word bits 10 and 9 with two reference bits. A word that passes every filter that is switched on goes into a 4-deep by 32-bit receive FIFO. The host drains that FIFO through a read port that presents the oldest word ahead of the pop. The control bits and the label-table write port are plain input pins.

Bit numbering follows the line order: word bit 1 is the first bit received and is carried on `word_i[0]`. Bit 32 is `word_i[31]`. The label is bits 1 to 8 (`word_i[7:0]`), and bits 10 and 9 are `word_i[9:8]`.

The sequencer has three states:
- `ST_IDLE` waits for the strobe. On `eos_i` it latches the word and takes the transition *capture* to `ST_CHECK`.
- `ST_CHECK` evaluates the filters. It takes *accept* to `ST_WRITE` when every enabled filter passes, and *reject* back to `ST_IDLE` otherwise.
- `ST_WRITE` drives the FIFO push for one cycle and takes *commit* back to `ST_IDLE`.

A word that arrives on the strobe edge is visible at the FIFO output after the third rising edge, counting the strobe edge as the first.

Top module: `arinc_rx_filter`

## Requirements
- R1: After reset the FIFO is empty (`empty_o`=1, `full_o`=0). Every label-table entry holds 8'h00.
- R2: With `par_en_i`=1, bits 1..31 are stored unchanged. Bit 32 is stored as 0 when the 32 received bits hold an odd number of ones, and as 1 when they hold an even number.
- R3: With `par_en_i`=0, the 32 bits are stored exactly as received.
- R4: A word is evaluated only on a cycle where `eos_i`=1 in `ST_IDLE`. Changes on `word_i` without the strobe store nothing. An accepted word is visible on `rd_data_o` after the third rising edge counted from the strobe edge.
- R5: With `lbl_en_i`=0, the label has no effect on acceptance.
- R6: With `lbl_en_i`=1, a word is accepted only if `word_i[7:0]` equals one of the 16 table entries.
- R7: When `tbl_we_i`=1 at a rising edge, entry `tbl_idx_i` takes the value `tbl_val_i`. No other entry changes.
- R8: With `sdi_en_i`=1, a word is accepted only if `word_i[9:8]` equals `sdi_ref_i` (`sdi_ref_i[1]` is bit 10). With `sdi_en_i`=0, those bits have no effect.
- R9: A word is stored only if all enabled filters pass. A word that fails any enabled filter is discarded.
- R10: The FIFO holds 4 words and returns them oldest first. `full_o` is 1 exactly when 4 words are held.
- R11: A word accepted while the FIFO is full is dropped, and the stored words are unchanged.
- R12: `rd_en_i` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eos_i | input | 1 | End-of-sequence strobe: the word on `word_i` is complete |
| word_i | input | 32 | Received word, bit 1 in position 0 |
| par_en_i | input | 1 | Parity check and bit-32 rewrite enable |
| lbl_en_i | input | 1 | Label filter enable |
| sdi_en_i | input | 1 | Bit 10/9 filter enable |
| sdi_ref_i | input | 2 | Reference for word bits 10 (bit 1) and 9 (bit 0) |
| tbl_we_i | input | 1 | Label table write strobe |
| tbl_idx_i | input | 4 | Label table entry index |
| tbl_val_i | input | 8 | Label value to write |
| rd_en_i | input | 1 | Pop the oldest FIFO word |
| rd_data_o | output | 32 | Oldest FIFO word |
| empty_o | output | 1 | FIFO holds no words |
| full_o | output | 1 | FIFO holds 4 words |

## Verification
The assertions assume the following about the inputs:
- `eos_i` is a single-cycle pulse that does not arrive while a word is still in `ST_CHECK` or `ST_WRITE`.
- The control and enable pins stay stable from the strobe until the push has completed.
- The label table is not written in that same window.

The stimulus meets these assumptions. It changes configuration and table contents only while the sequencer is idle, and it waits several cycles after every strobe before it drives anything else.

// File: rtl/arinc_filt_pkg.sv
package arinc_filt_pkg;
    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WRITE = 2'd2
    } filt_state_e;
endpackage

// File: rtl/label_table.sv
module label_table #(
    parameter int LBL_W = 8,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [LBL_W-1:0] val,
    input  logic [LBL_W-1:0] probe,
    output logic             hit
);
    logic [LBL_W-1:0] entry_q [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                entry_q[g] <= val;
            end
        end
        assign match[g] = (entry_q[g] == probe);
    end

    assign hit = |match;

    // R7
    tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (entry_q[$past(idx)] == $past(val)));
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rd_ptr_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (do_push && (wr_ptr_q == PTR_W'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && $stable(wr_ptr_q) && $stable(rdata)));

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && $stable(rd_ptr_q)));

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/arinc_rx_filter.sv
module arinc_rx_filter
    import arinc_filt_pkg::*;
#(
    parameter int TBL_DEPTH  = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eos_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              par_en_i,
    input  logic              lbl_en_i,
    input  logic              sdi_en_i,
    input  logic [1:0]        sdi_ref_i,
    input  logic              tbl_we_i,
    input  logic [IDX_W-1:0]  tbl_idx_i,
    input  logic [LBL_W-1:0]  tbl_val_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              full_o
);
    filt_state_e       state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              lbl_hit;
    logic              sdi_ok;
    logic              pass;
    logic              push;
    logic [WORD_W-1:0] store_word;

    label_table #(.LBL_W(LBL_W), .DEPTH(TBL_DEPTH)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we_i),
        .idx   (tbl_idx_i),
        .val   (tbl_val_i),
        .probe (word_q[LBL_W-1:0]),
        .hit   (lbl_hit)
    );

    assign sdi_ok = (word_q[9:8] == sdi_ref_i);
    assign pass   = (!lbl_en_i || lbl_hit) && (!sdi_en_i || sdi_ok);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && eos_i) word_q <= word_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (eos_i) state_d = ST_CHECK;
            ST_CHECK: state_d = pass ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push       = 1'b0;
        store_word = word_q;
        if (par_en_i) store_word[WORD_W-1] = ~(^word_q);
        unique case (state_q)
            ST_WRITE: push = 1'b1;
            default:  push = 1'b0;
        endcase
    end

    word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (store_word),
        .pop   (rd_en_i),
        .rdata (rd_data_o),
        .empty (empty_o),
        .full  (full_o)
    );

    // R4
    eos_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && eos_i) |=> (state_q == ST_CHECK && word_q == $past(word_i)));

    // R4
    write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> ($past(state_q) == ST_CHECK));

    // R6
    label_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && lbl_en_i) |-> lbl_hit);

    // R8
    sdi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && sdi_en_i) |-> (word_q[9:8] == sdi_ref_i));
endmodule

// File: tb/arinc_rx_filter_test.sv
`timescale 1ns/1ps
module arinc_rx_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eos_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        par_en_i = 1'b0, lbl_en_i = 1'b0, sdi_en_i = 1'b0;
    logic [1:0]  sdi_ref_i = '0;
    logic        tbl_we_i = 1'b0;
    logic [3:0]  tbl_idx_i = '0;
    logic [7:0]  tbl_val_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        empty_o, full_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] tbl_m [16];

    always #5 clk = ~clk;

    arinc_rx_filter uut (
        .clk(clk), .rst_n(rst_n), .eos_i(eos_i), .word_i(word_i),
        .par_en_i(par_en_i), .lbl_en_i(lbl_en_i), .sdi_en_i(sdi_en_i),
        .sdi_ref_i(sdi_ref_i), .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i),
        .tbl_val_i(tbl_val_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        word_i = w;
        eos_i  = 1'b1;
        @(negedge clk);
        eos_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic twrite(input int i, input logic [7:0] v);
        @(negedge clk);
        tbl_we_i = 1'b1;
        tbl_idx_i = 4'(i);
        tbl_val_i = v;
        @(negedge clk);
        tbl_we_i = 1'b0;
        tbl_m[i] = v;
    endtask

    function automatic logic [31:0] model_word(input logic [31:0] w, input logic pe);
        logic [31:0] r = w;
        if (pe) r[31] = ($countones(w) % 2 == 1) ? 1'b0 : 1'b1;
        return r;
    endfunction

    function automatic bit model_pass(input logic [31:0] w);
        bit lh = 1'b0;
        for (int i = 0; i < 16; i++) if (tbl_m[i] == w[7:0]) lh = 1'b1;
        return (!lbl_en_i || lh) && (!sdi_en_i || w[9:8] == sdi_ref_i);
    endfunction

    // send one word and compare the FIFO outcome with the model
    task automatic run_word(input logic [31:0] w, input string req);
        bit p;
        logic [31:0] e;
        p = model_pass(w);
        e = model_word(w, par_en_i);
        send(w);
        if (p) begin
            chk(!empty_o && rd_data_o == e, req, rd_data_o, e);
            pop();
            chk(empty_o, req, {31'd0, empty_o}, 32'd1);
        end else begin
            chk(empty_o, req, {31'd0, empty_o}, 32'd1);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tbl_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(empty_o && !full_o, "R1", {30'd0, empty_o, full_o}, 32'd2);
        lbl_en_i = 1'b1;
        run_word(32'h1234_5600, "R1");   // label 00 matches a cleared table
        run_word(32'h1234_5601, "R1");
        lbl_en_i = 1'b0;

        // R4: word change without strobe stores nothing
        @(negedge clk);
        word_i = 32'hDEAD_BEEF;
        repeat (5) @(negedge clk);
        chk(empty_o, "R4", {31'd0, empty_o}, 32'd1);
        // R4 latency: not visible after second edge, visible after third
        @(negedge clk);
        word_i = 32'hCAFE_0001;
        eos_i = 1'b1;
        @(negedge clk);
        eos_i = 1'b0;
        @(negedge clk);
        chk(empty_o, "R4", {31'd0, empty_o}, 32'd1);
        @(negedge clk);
        chk(!empty_o && rd_data_o == 32'hCAFE_0001, "R4", rd_data_o, 32'hCAFE_0001);
        pop();

        // R3 / R2 parity sweep over walking and mixed patterns
        for (int pe = 0; pe < 2; pe++) begin
            par_en_i = pe[0];
            for (int b = 0; b < 32; b++) begin
                run_word((32'h1 << b), pe ? "R2" : "R3");
                run_word((32'h1 << b) ^ 32'h8000_0003, pe ? "R2" : "R3");
            end
        end
        par_en_i = 1'b0;

        // R7 table load with distinct labels, R6 full label sweep
        for (int i = 0; i < 16; i++) twrite(i, 8'((i * 13) + 5));
        lbl_en_i = 1'b1;
        for (int l = 0; l < 256; l++) run_word({8'hA5, 14'd0, 2'b01, 8'(l)}, "R6");
        // R7: overwrite one entry, old label gone, new present
        twrite(3, 8'hF0);
        run_word(32'h0000_00F0, "R7");
        run_word(32'h0000_002C, "R7");  // 3*13+5 = 44 = 0x2C removed
        // R5: filter off, any label passes
        lbl_en_i = 1'b0;
        for (int l = 0; l < 256; l += 17) run_word(32'h0100_0000 | 32'(l), "R5");

        // R8 bit 10/9 sweep, R9 combined
        for (int en = 0; en < 2; en++) begin
            sdi_en_i = en[0];
            for (int r = 0; r < 4; r++) begin
                sdi_ref_i = 2'(r);
                for (int v = 0; v < 4; v++) run_word({22'h2AAAA, 2'(v), 8'h05}, "R8");
            end
        end
        lbl_en_i = 1'b1;
        sdi_en_i = 1'b1;
        sdi_ref_i = 2'b10;
        run_word({22'h0, 2'b10, 8'h05}, "R9");
        run_word({22'h0, 2'b01, 8'h05}, "R9");
        run_word({22'h0, 2'b10, 8'h06}, "R9");
        run_word({22'h0, 2'b01, 8'h06}, "R9");
        lbl_en_i = 1'b0;
        sdi_en_i = 1'b0;

        // R10 fill, R11 overflow drop, R12 underflow
        for (int k = 0; k < 4; k++) begin
            chk(!full_o, "R10", {31'd0, full_o}, 32'd0);
            send(32'h5000_0000 + 32'(k));
        end
        chk(full_o, "R10", {31'd0, full_o}, 32'd1);
        send(32'h5000_00FF);
        chk(full_o && rd_data_o == 32'h5000_0000, "R11", rd_data_o, 32'h5000_0000);
        for (int k = 0; k < 4; k++) begin
            chk(!empty_o && rd_data_o == 32'h5000_0000 + 32'(k), "R10", rd_data_o, 32'h5000_0000 + 32'(k));
            pop();
        end
        chk(empty_o, "R11", {31'd0, empty_o}, 32'd1);
        pop();
        pop();
        chk(empty_o && !full_o, "R12", {30'd0, empty_o, full_o}, 32'd2);
        send(32'h7777_0001);
        chk(!empty_o && rd_data_o == 32'h7777_0001, "R12", rd_data_o, 32'h7777_0001);
        pop();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule